// File: doc/BRIEF.md
# Dual-Clock Dual-Port RAM with Per-Port Aspect Ratio

A 4096-bit embedded memory with two ports, A and B. Both ports reach one shared bit array, and each port can read and write it. Each port has its own word width, chosen by a parameter from 1, 2, 4, 8 or 16 bits. A port of width W addresses 4096/W words. Word n of that port covers array bits n*W up to n*W+W-1, so a narrow port and a wide port see the same bits, low-order bits first.

The address, write data, byte enable and write enable of each port are captured in an input register group. The read data leaves through an output register group. Each group has its own clock enable and its own asynchronous clear.

The parameter `CLK_MODE` selects how the groups are clocked. With `CLK_MODE` = 0 (independent clocks), each port's input clock drives both of that port's groups, and its output-clock pin is ignored. With `CLK_MODE` = 1 (split input/output clocks), the input clock drives the input group and the output clock drives the output group.

Top module: `dcram_4k`

## Requirements
- R1: A port of width W (1, 2, 4, 8 or 16) has an address of log2(4096/W) bits, and every word from 0 up to 4096/W-1 can be written and read back.
- R2: Word n of a width-W port occupies array bits n*W .. n*W+W-1, with data bit 0 at the lowest array bit. Data written through one port is read back through the other port in that layout.
- R3: The inputs are captured on an enabled input-clock edge. The array is written on the following input-clock edge, and only if the captured write enable is 1. The read data appears after the first enabled output-clock edge that follows the capture. A read during a write on the same port returns the word's old contents.
- R4: Byte enable bit 0 gates data bits 7:0 of a write. Bit 1 gates data bits 15:8, and is used only when the port width is 16. At widths of 8 or less, bit 1 has no effect. Bits whose enable is 0 keep their contents.
- R5: A captured write enable of 0 leaves the array unchanged, whatever the address and data.
- R6: While a port's input clock enable is 0, its input register group holds the last captured address, data, byte enable and write enable.
- R7: While a port's output clock enable is 0, its read-data output holds its value.
- R8: A port's output clear asynchronously forces its read data to 0. The data stays 0 until the first output-clock edge at which the clear is released and the output clock enable is 1. The read data is 0 after the block is cleared.
- R9: A port's input clear asynchronously zeroes its input register group: address 0 and write enable 0. A write presented while the clear is held is not performed.
- R10: With CLK_MODE=1 the output group of port A updates only on edges of `a_clk_out`. With CLK_MODE=0 it updates on edges of `a_clk_in`, and `a_clk_out` is ignored.
- R11: Port B has clocks, enables and clears of its own, and the same behaviour as port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_in | input | 1 | Port A input-group clock; also the output clock when CLK_MODE=0 |
| a_clk_out | input | 1 | Port A output-group clock when CLK_MODE=1 |
| a_ce_in | input | 1 | Port A input-group clock enable |
| a_ce_out | input | 1 | Port A output-group clock enable |
| a_clr_in | input | 1 | Port A input-group asynchronous clear, active high |
| a_clr_out | input | 1 | Port A output-group asynchronous clear, active high |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_be | input | 2 | Port A byte enables (bit 1 used only at width 16) |
| a_we | input | 1 | Port A write enable |
| a_q | output | A_WIDTH | Port A registered read data |
| b_clk_in | input | 1 | Port B input-group clock; also the output clock when CLK_MODE=0 |
| b_clk_out | input | 1 | Port B output-group clock when CLK_MODE=1 |
| b_ce_in | input | 1 | Port B input-group clock enable |
| b_ce_out | input | 1 | Port B output-group clock enable |
| b_clr_in | input | 1 | Port B input-group asynchronous clear, active high |
| b_clr_out | input | 1 | Port B output-group asynchronous clear, active high |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_be | input | 2 | Port B byte enables (bit 1 used only at width 16) |
| b_we | input | 1 | Port B write enable |
| b_q | output | B_WIDTH | Port B registered read data |

## Verification
Some properties are checked by the assertions on every clock edge:
- the read data is zero whenever an output clear is sampled;
- an output register and the port A input address register hold whenever their enable was low;
- the captured write enable is zero whenever an input clear is sampled.

Other behaviour can only be shown by the bench's scenarios, which compare data read back against a bit-level model of the array:
- the bit layout shared between a 16-bit port and a 4-bit port;
- byte masking;
- old data returned on a read during a write;
- writes dropped under an input clear;
- an output register that waits for its own clock in split-clock mode;
- a second instance in independent-clock mode, which checks that the unused output clock and the upper byte enable have no effect.

// File: rtl/dcram_4k.sv
module dcram_4k #(
  parameter int TOTAL_BITS = 4096,
  parameter int CLK_MODE   = 0,
  parameter int A_WIDTH    = 16,
  parameter int B_WIDTH    = 16,
  localparam int A_AW = $clog2(TOTAL_BITS / A_WIDTH),
  localparam int B_AW = $clog2(TOTAL_BITS / B_WIDTH)
) (
  input  logic               a_clk_in,
  input  logic               a_clk_out,
  input  logic               a_ce_in,
  input  logic               a_ce_out,
  input  logic               a_clr_in,
  input  logic               a_clr_out,
  input  logic [A_AW-1:0]    a_addr,
  input  logic [A_WIDTH-1:0] a_wdata,
  input  logic [1:0]         a_be,
  input  logic               a_we,
  output logic [A_WIDTH-1:0] a_q,
  input  logic               b_clk_in,
  input  logic               b_clk_out,
  input  logic               b_ce_in,
  input  logic               b_ce_out,
  input  logic               b_clr_in,
  input  logic               b_clr_out,
  input  logic [B_AW-1:0]    b_addr,
  input  logic [B_WIDTH-1:0] b_wdata,
  input  logic [1:0]         b_be,
  input  logic               b_we,
  output logic [B_WIDTH-1:0] b_q
);
  localparam int BIT_AW = $clog2(TOTAL_BITS);
  localparam int A_SH   = $clog2(A_WIDTH);
  localparam int B_SH   = $clog2(B_WIDTH);

  logic [TOTAL_BITS-1:0] bank_a, bank_b;

  logic a_iclk, a_oclk, b_iclk, b_oclk;
  assign a_iclk = a_clk_in;
  assign b_iclk = b_clk_in;
  assign a_oclk = (CLK_MODE == 1) ? a_clk_out : a_clk_in;
  assign b_oclk = (CLK_MODE == 1) ? b_clk_out : b_clk_in;

  logic [A_AW-1:0]    a_addr_q;
  logic [A_WIDTH-1:0] a_wd_q, a_rd;
  logic [1:0]         a_be_q;
  logic               a_we_q;
  logic [BIT_AW-1:0]  a_base;

  logic [B_AW-1:0]    b_addr_q;
  logic [B_WIDTH-1:0] b_wd_q, b_rd;
  logic [1:0]         b_be_q;
  logic               b_we_q;
  logic [BIT_AW-1:0]  b_base;

  assign a_base = BIT_AW'(a_addr_q) << A_SH;
  assign b_base = BIT_AW'(b_addr_q) << B_SH;

  always_ff @(posedge a_iclk or posedge a_clr_in) begin
    if (a_clr_in) begin
      a_addr_q <= '0;
      a_wd_q   <= '0;
      a_be_q   <= '0;
      a_we_q   <= 1'b0;
    end else if (a_ce_in) begin
      a_addr_q <= a_addr;
      a_wd_q   <= a_wdata;
      a_be_q   <= a_be;
      a_we_q   <= a_we;
    end
  end

  always_ff @(posedge b_iclk or posedge b_clr_in) begin
    if (b_clr_in) begin
      b_addr_q <= '0;
      b_wd_q   <= '0;
      b_be_q   <= '0;
      b_we_q   <= 1'b0;
    end else if (b_ce_in) begin
      b_addr_q <= b_addr;
      b_wd_q   <= b_wdata;
      b_be_q   <= b_be;
      b_we_q   <= b_we;
    end
  end

  // each bank has a single writer; stored bit = bank_a ^ bank_b
  always_ff @(posedge a_iclk) begin
    if (a_we_q) begin
      for (int i = 0; i < A_WIDTH; i++) begin
        if ((A_WIDTH > 8 && i >= 8) ? a_be_q[1] : a_be_q[0])
          bank_a[a_base + BIT_AW'(i)] <= a_wd_q[i] ^ bank_b[a_base + BIT_AW'(i)];
      end
    end
  end

  always_ff @(posedge b_iclk) begin
    if (b_we_q) begin
      for (int i = 0; i < B_WIDTH; i++) begin
        if ((B_WIDTH > 8 && i >= 8) ? b_be_q[1] : b_be_q[0])
          bank_b[b_base + BIT_AW'(i)] <= b_wd_q[i] ^ bank_a[b_base + BIT_AW'(i)];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < A_WIDTH; i++)
      a_rd[i] = bank_a[a_base + BIT_AW'(i)] ^ bank_b[a_base + BIT_AW'(i)];
  end

  always_comb begin
    for (int i = 0; i < B_WIDTH; i++)
      b_rd[i] = bank_a[b_base + BIT_AW'(i)] ^ bank_b[b_base + BIT_AW'(i)];
  end

  always_ff @(posedge a_oclk or posedge a_clr_out) begin
    if (a_clr_out)     a_q <= '0;
    else if (a_ce_out) a_q <= a_rd;
  end

  always_ff @(posedge b_oclk or posedge b_clr_out) begin
    if (b_clr_out)     b_q <= '0;
    else if (b_ce_out) b_q <= b_rd;
  end
endmodule

// File: rtl/dcram_4k_chk.sv
module dcram_4k_chk #(
  parameter int A_WIDTH = 16,
  parameter int B_WIDTH = 16,
  parameter int A_AW    = 8
) (
  input logic               a_iclk,
  input logic               a_oclk,
  input logic               b_iclk,
  input logic               b_oclk,
  input logic               a_ce_in,
  input logic               a_ce_out,
  input logic               b_ce_out,
  input logic               a_clr_in,
  input logic               a_clr_out,
  input logic               b_clr_in,
  input logic               b_clr_out,
  input logic               a_we_q,
  input logic               b_we_q,
  input logic [A_AW-1:0]    a_addr_q,
  input logic [A_WIDTH-1:0] a_q,
  input logic [B_WIDTH-1:0] b_q
);
  AST_A_OUT_CLEAR_ZERO: assert property (@(posedge a_oclk) a_clr_out |-> (a_q == '0)); // R8
  AST_B_OUT_CLEAR_ZERO: assert property (@(posedge b_oclk) b_clr_out |-> (b_q == '0)); // R8

  AST_A_OUT_HOLD: assert property (@(posedge a_oclk) disable iff (a_clr_out)
    (!$past(a_ce_out) && !$past(a_clr_out)) |-> (a_q == $past(a_q))); // R7
  AST_B_OUT_HOLD: assert property (@(posedge b_oclk) disable iff (b_clr_out)
    (!$past(b_ce_out) && !$past(b_clr_out)) |-> (b_q == $past(b_q))); // R7

  AST_A_IN_HOLD: assert property (@(posedge a_iclk) disable iff (a_clr_in)
    (!$past(a_ce_in) && !$past(a_clr_in)) |-> (a_addr_q == $past(a_addr_q))); // R6

  AST_A_CLR_NO_WE: assert property (@(posedge a_iclk) a_clr_in |-> !a_we_q); // R9
  AST_B_CLR_NO_WE: assert property (@(posedge b_iclk) b_clr_in |-> !b_we_q); // R9
endmodule

bind dcram_4k dcram_4k_chk #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .A_AW(A_AW)) u_chk (
  .a_iclk(a_iclk), .a_oclk(a_oclk), .b_iclk(b_iclk), .b_oclk(b_oclk),
  .a_ce_in(a_ce_in), .a_ce_out(a_ce_out), .b_ce_out(b_ce_out),
  .a_clr_in(a_clr_in), .a_clr_out(a_clr_out), .b_clr_in(b_clr_in), .b_clr_out(b_clr_out),
  .a_we_q(a_we_q), .b_we_q(b_we_q), .a_addr_q(a_addr_q), .a_q(a_q), .b_q(b_q)
);

// File: tb/dcram_4k_tb_top.sv
module dcram_4k_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  logic a_run = 1'b1;
  logic a_oclk_g;
  assign a_oclk_g = clk & a_run;

  logic a_ce_in = 1'b1, a_ce_out = 1'b1, a_clr_in = 1'b1, a_clr_out = 1'b1;
  logic b_ce_in = 1'b1, b_ce_out = 1'b1, b_clr_in = 1'b1, b_clr_out = 1'b1;
  logic [7:0]  a_addr = '0;
  logic [15:0] a_wdata = '0;
  logic [1:0]  a_be = 2'b11;
  logic        a_we = 1'b0;
  logic [15:0] a_q;
  logic [9:0]  b_addr = '0;
  logic [3:0]  b_wdata = '0;
  logic [1:0]  b_be = 2'b11;
  logic        b_we = 1'b0;
  logic [3:0]  b_q;

  dcram_4k #(.CLK_MODE(1), .A_WIDTH(16), .B_WIDTH(4)) dut_i (
    .a_clk_in(clk), .a_clk_out(a_oclk_g), .a_ce_in(a_ce_in), .a_ce_out(a_ce_out),
    .a_clr_in(a_clr_in), .a_clr_out(a_clr_out), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_be(a_be), .a_we(a_we), .a_q(a_q),
    .b_clk_in(clk), .b_clk_out(clk), .b_ce_in(b_ce_in), .b_ce_out(b_ce_out),
    .b_clr_in(b_clr_in), .b_clr_out(b_clr_out), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_be(b_be), .b_we(b_we), .b_q(b_q)
  );

  logic        i_clr = 1'b1;
  logic [8:0]  i_a_addr = '0;
  logic [7:0]  i_a_wdata = '0;
  logic [1:0]  i_a_be = 2'b01;
  logic        i_a_we = 1'b0;
  logic [7:0]  i_a_q;
  logic [11:0] i_b_addr = '0;
  logic [0:0]  i_b_q;

  dcram_4k #(.CLK_MODE(0), .A_WIDTH(8), .B_WIDTH(1)) dut_ind (
    .a_clk_in(clk), .a_clk_out(1'b0), .a_ce_in(1'b1), .a_ce_out(1'b1),
    .a_clr_in(i_clr), .a_clr_out(i_clr), .a_addr(i_a_addr), .a_wdata(i_a_wdata),
    .a_be(i_a_be), .a_we(i_a_we), .a_q(i_a_q),
    .b_clk_in(clk), .b_clk_out(1'b0), .b_ce_in(1'b1), .b_ce_out(1'b1),
    .b_clr_in(i_clr), .b_clr_out(i_clr), .b_addr(i_b_addr), .b_wdata(1'b0),
    .b_be(2'b01), .b_we(1'b0), .b_q(i_b_q)
  );

  logic [4095:0] mdl = '0;
  logic [4095:0] mdl_ok = '0;
  int          q_due[$];
  logic [16:0] q_exp[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op_a(input int addr, input logic we, input logic [15:0] d,
                      input logic [1:0] be, input string tag);
    if (&mdl_ok[addr*16 +: 16]) begin
      q_due.push_back(cyc + 2);
      q_exp.push_back({1'b0, mdl[addr*16 +: 16]});
      q_tag.push_back(tag);
    end
    if (we)
      for (int i = 0; i < 16; i++)
        if ((i >= 8) ? be[1] : be[0]) begin
          mdl[addr*16 + i] = d[i];
          mdl_ok[addr*16 + i] = 1'b1;
        end
    a_addr = 8'(addr); a_we = we; a_wdata = d; a_be = be; b_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic op_b(input int addr, input logic we, input logic [3:0] d,
                      input logic [1:0] be, input string tag);
    if (&mdl_ok[addr*4 +: 4]) begin
      q_due.push_back(cyc + 2);
      q_exp.push_back({1'b1, 12'h0, mdl[addr*4 +: 4]});
      q_tag.push_back(tag);
    end
    if (we && be[0])
      for (int i = 0; i < 4; i++) begin
        mdl[addr*4 + i] = d[i];
        mdl_ok[addr*4 + i] = 1'b1;
      end
    b_addr = 10'(addr); b_we = we; b_wdata = d; b_be = be; a_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    a_we = 1'b0; b_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] wa(input int addr);
    return mdl[addr*16 +: 16];
  endfunction

  always @(negedge clk) begin
    string t;
    logic [16:0] e;
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      void'(q_due.pop_front());
      if (e[16]) check(t, {12'h0, b_q}, {12'h0, e[3:0]});
      else       check(t, a_q, e[15:0]);
    end
  end

  initial begin
    repeat (500000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset a_q", a_q, 16'h0);
    check("R8 reset b_q", {12'h0, b_q}, 16'h0);
    check("R8 reset ind a_q", {8'h0, i_a_q}, 16'h0);
    a_clr_in = 0; a_clr_out = 0; b_clr_in = 0; b_clr_out = 0; i_clr = 0;
    @(negedge clk);

    // R1 fill every 16-bit word; RDW checks come in once words are known (R3)
    for (int w = 0; w < 256; w++) op_a(w, 1'b1, 16'(w * 40503) ^ 16'h5A5A, 2'b11, "R1 fill");
    op_a(0, 1'b0, 16'h0, 2'b11, "R1 read word 0");
    op_a(255, 1'b0, 16'h0, 2'b11, "R1 read word 255");
    op_a(128, 1'b0, 16'h0, 2'b11, "R3 read word 128");
    // R2 nibble view through port B
    op_b(0, 1'b0, 4'h0, 2'b01, "R2 B word 0");
    op_b(1, 1'b0, 4'h0, 2'b01, "R2 B word 1");
    op_b(7, 1'b0, 4'h0, 2'b01, "R2 B word 7");
    op_b(1023, 1'b0, 4'h0, 2'b01, "R1 B word 1023");
    // R11 port B writes seen by port A
    op_b(1023, 1'b1, 4'h3, 2'b01, "R11 B write 1023");
    op_a(255, 1'b0, 16'h0, 2'b11, "R2 A sees B write");
    op_b(5, 1'b1, 4'hC, 2'b01, "R11 B write 5");
    op_b(5, 1'b0, 4'h0, 2'b01, "R11 B readback 5");
    op_a(1, 1'b0, 16'h0, 2'b11, "R2 A word 1 after B write");
    op_b(6, 1'b1, 4'h9, 2'b00, "R4 B write be0 off");
    op_b(6, 1'b0, 4'h0, 2'b01, "R4 B unchanged");
    // R4 byte masking
    op_a(10, 1'b1, 16'h1234, 2'b01, "R4 low byte write");
    op_a(10, 1'b1, 16'hABCD, 2'b10, "R4 high byte write");
    op_a(10, 1'b1, 16'hFFFF, 2'b00, "R4 no byte write");
    op_a(10, 1'b0, 16'h0, 2'b11, "R4 masked result");
    // R5 disabled write
    op_a(11, 1'b0, 16'h0F0F, 2'b11, "R5 we low");
    op_a(11, 1'b0, 16'h0, 2'b11, "R5 unchanged");
    // R3 back-to-back same-word writes return the previous data
    op_a(20, 1'b1, 16'h1111, 2'b11, "R3 rdw first");
    op_a(20, 1'b1, 16'h2222, 2'b11, "R3 rdw second");
    op_a(20, 1'b0, 16'h0, 2'b11, "R3 rdw final");
    op_a(40, 1'b0, 16'h0, 2'b11, "R3 read 40");

    // R6 input enable low: held address 40 and held we=0
    a_ce_in = 1'b0; a_addr = 8'd41; a_we = 1'b1; a_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    check("R6 held address", a_q, wa(40));
    a_we = 1'b0; a_ce_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no write while held", a_q, wa(41));

    // R7 output enable low
    a_addr = 8'd42; a_ce_out = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 output held", a_q, wa(41));
    // R8 output clear
    a_clr_out = 1'b1;
    @(negedge clk);
    check("R8 clear forces zero", a_q, 16'h0);
    a_clr_out = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 zero until enabled edge", a_q, 16'h0);
    a_ce_out = 1'b1;
    @(negedge clk);
    check("R8 data after enabled edge", a_q, wa(42));

    // R9 input clear drops write and zeroes address
    a_clr_in = 1'b1; a_addr = 8'd30; a_we = 1'b1; a_wdata = 16'hFFFF;
    repeat (2) @(negedge clk);
    a_clr_in = 1'b0; a_we = 1'b0; a_ce_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 address cleared to 0", a_q, wa(0));
    a_ce_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 write dropped", a_q, wa(30));

    // R10 split clocks: output waits for a_clk_out
    a_run = 1'b0; a_addr = 8'd50;
    repeat (3) @(negedge clk);
    check("R10 no output clock", a_q, wa(30));
    a_run = 1'b1;
    @(negedge clk);
    check("R10 output clock resumes", a_q, wa(50));

    // R10 independent mode instance, output clock pin tied low
    i_a_addr = 9'd3; i_a_wdata = 8'hA5; i_a_be = 2'b01; i_a_we = 1'b1;
    @(negedge clk);
    i_a_we = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 ind out on input clock", {8'h0, i_a_q}, 16'h00A5);
    i_b_addr = 12'd24;
    repeat (2) @(negedge clk);
    check("R2 ind bit 24", {15'h0, i_b_q}, 16'h1);
    i_b_addr = 12'd29;
    repeat (2) @(negedge clk);
    check("R2 ind bit 29", {15'h0, i_b_q}, 16'h1);
    i_b_addr = 12'd30;
    repeat (2) @(negedge clk);
    check("R2 ind bit 30", {15'h0, i_b_q}, 16'h0);
    i_a_wdata = 8'h00; i_a_be = 2'b10; i_a_we = 1'b1;
    @(negedge clk);
    i_a_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 be1 ignored at width 8", {8'h0, i_a_q}, 16'h00A5);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule